// File: doc/BRIEF.md
# Edge-Referenced Timestamp Capture Unit

The unit stamps rising edges of an external once-per-second style pulse against a free-running timebase. Both the timebase and a second "age" counter advance on a shared tick that a prescaler derives from the core clock, by default every fourth cycle. The timebase never stops and wraps at its full width. The age counter restarts on every synchronized rising edge and then counts how long ago that edge occurred. The edge time is not stored at the edge. It is rebuilt when the host polls, as timebase minus age, modulo the counter width.

The host polls through a request/response pair with valid/ready on both sides. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high only while no response is pending. In the accepting cycle the unit latches the rebuilt timestamp and the synchronized input level together, so the two always belong to the same cycle. The response stays on the pins, unchanged, until the host takes it with `rsp_ready`; this is the only back-pressure the unit applies. Each response also carries a flag for a new assert event since the previous poll. An echo pin follows the poll results, and a control pin can invert it.

Top module: `edge_stamp_unit`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1, `echo_out` equals `echo_invert`, and the first response reports `rsp_armed` = 0 if no edge has been seen.
- R2: The timebase advances by one every DIV clock cycles (the first step comes DIV cycles after reset) and wraps from 2^W-1 to 0. While no edge has occurred, the age counter stays at 0, so a poll returns the timebase value.
- R3: `pps_in` passes through a two-stage synchronizer. The rising edge that is used is the 0-to-1 transition at the synchronizer output, two clocks after the input is sampled. Each such edge restarts the age count and sets the armed state, which only reset clears.
- R4: A poll returns `rsp_stamp` equal to the timebase value in the clock cycle where the synchronized edge was detected. This value is taken as the timebase minus the age, modulo 2^W. Later polls therefore return the same stamp until the next edge, provided the age stays below 2^W ticks.
- R5: A poll accepted in the very cycle of an edge returns that edge's stamp and reports `rsp_level` = 1 and `rsp_armed` = 1.
- R6: `rsp_new` = 1 exactly when the sampled level is 1 and the level sampled by the previous accepted poll was 0 (taken as 0 after reset).
- R7: The internal echo state becomes 1 on a poll with `rsp_new` = 1. It becomes 0 on a poll that samples level 0 after a poll that sampled 1. Otherwise it holds. `echo_out` is that state XOR `echo_invert`.
- R8: While `rsp_valid` = 1 and `rsp_ready` = 0, the response fields hold and `req_ready` stays 0. The response clears on the cycle after `rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_in | input | 1 | External pulse input, asynchronous |
| echo_invert | input | 1 | Inverts the echo output |
| req_valid | input | 1 | Host poll request |
| req_ready | output | 1 | Unit can accept a poll |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_stamp | output | W | Rebuilt edge timestamp |
| rsp_level | output | 1 | Synchronized input level at poll time |
| rsp_new | output | 1 | New assert event since the previous poll |
| rsp_armed | output | 1 | At least one edge seen since reset |
| echo_out | output | 1 | Echo of poll results |

## Verification
The bench builds the unit with W = 8 and DIV = 4. The timebase then wraps every 1024 clocks, so wrap of both the timebase and the age counter and the modular subtraction all occur many times in a short run. A prescale of 4 keeps tick and non-tick cycles distinct. Edges that land on a tick cycle, and polls that land on the edge cycle, are therefore both reached, and a directed case forces the latter.

// File: rtl/esu_pkg.sv
package esu_pkg;
  typedef struct packed {
    logic level;
    logic fresh;
    logic armed;
  } poll_flags_t;
endpackage

// File: rtl/esu_tick_div.sv
module esu_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/esu_sync_edge.sv
module esu_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              level_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q   <= '0;
      level_d_q <= 1'b0;
    end else begin
      chain_q   <= {chain_q[STAGES-2:0], async_in};
      level_d_q <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~level_d_q;
endmodule

// File: rtl/esu_counters.sv
module esu_counters #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         rise,
  output logic [W-1:0] free_cnt,
  output logic [W-1:0] age_cnt,
  output logic         armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    free_cnt <= '0;
    else if (tick) free_cnt <= free_cnt + 1'b1;
  end

  // The age count includes the tick of the edge cycle itself, so that
  // timebase minus age always lands on the timebase of that cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_cnt <= '0;
      armed   <= 1'b0;
    end else if (rise) begin
      age_cnt <= W'(tick);
      armed   <= 1'b1;
    end else if (armed && tick) begin
      age_cnt <= age_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/esu_poll.sv
module esu_poll
  import esu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  input  logic [W-1:0] stamp_now,
  input  logic         level,
  input  logic         armed_now,
  input  logic         echo_invert,
  output logic [W-1:0] rsp_stamp,
  output poll_flags_t  rsp_flags,
  output logic         echo_out
);
  logic prev_level_q;
  logic echo_q;
  logic accept;

  assign req_ready = ~rsp_valid;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_stamp    <= '0;
      rsp_flags    <= '0;
      prev_level_q <= 1'b0;
      echo_q       <= 1'b0;
    end else if (accept) begin
      rsp_valid       <= 1'b1;
      rsp_stamp       <= stamp_now;
      rsp_flags.level <= level;
      rsp_flags.fresh <= level & ~prev_level_q;
      rsp_flags.armed <= armed_now;
      prev_level_q    <= level;
      if (level && !prev_level_q)      echo_q <= 1'b1;
      else if (!level && prev_level_q) echo_q <= 1'b0;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign echo_out = echo_q ^ echo_invert;
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import esu_pkg::*;
#(
  parameter int W      = 16,
  parameter int DIV    = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pps_in,
  input  logic         echo_invert,
  input  logic         req_valid,
  output logic         req_ready,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_stamp,
  output logic         rsp_level,
  output logic         rsp_new,
  output logic         rsp_armed,
  output logic         echo_out
);
  logic         tick;
  logic         level;
  logic         rise;
  logic         armed;
  logic [W-1:0] free_cnt;
  logic [W-1:0] age_cnt;
  logic [W-1:0] stamp_now;
  poll_flags_t  flags;

  esu_tick_div #(.DIV(DIV)) u_div (.clk(clk), .rst_n(rst_n), .tick(tick));

  esu_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pps_in), .level(level), .rise(rise)
  );

  esu_counters #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rise(rise),
    .free_cnt(free_cnt), .age_cnt(age_cnt), .armed(armed)
  );

  // In the edge cycle the age register is still stale; the stamp is the
  // timebase itself.
  assign stamp_now = rise ? free_cnt : (free_cnt - age_cnt);

  esu_poll #(.W(W)) u_poll (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .stamp_now(stamp_now), .level(level), .armed_now(armed | rise),
    .echo_invert(echo_invert),
    .rsp_stamp(rsp_stamp), .rsp_flags(flags), .echo_out(echo_out)
  );

  assign rsp_level = flags.level;
  assign rsp_new   = flags.fresh;
  assign rsp_armed = flags.armed;
endmodule

// File: rtl/esu_checker.sv
module esu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         rise,
  input logic         armed,
  input logic [W-1:0] free_cnt,
  input logic [W-1:0] age_cnt,
  input logic         req_valid,
  input logic         req_ready,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_stamp,
  input logic         rsp_level,
  input logic         rsp_new
);
  // R2
  timebase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(free_cnt));

  // R2
  idle_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> age_cnt == '0);

  // R3
  edge_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> armed && (age_cnt <= W'(1)));

  // R6
  fresh_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_new |-> rsp_level);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_stamp) && !req_ready);

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
endmodule

bind edge_stamp_unit esu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rise(rise), .armed(armed),
  .free_cnt(free_cnt), .age_cnt(age_cnt),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_stamp(rsp_stamp), .rsp_level(rsp_level), .rsp_new(rsp_new)
);

// File: tb/sim_edge_stamp_unit.sv
module sim_edge_stamp_unit;
  localparam int W      = 8;
  localparam int DIV    = 4;
  localparam int PERIOD = 10;
  localparam int MASK   = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pps_in = 1'b0, echo_invert = 1'b0, req_valid = 1'b0, rsp_ready = 1'b0;
  logic req_ready, rsp_valid, rsp_level, rsp_new, rsp_armed, echo_out;
  logic [W-1:0] rsp_stamp;

  int errors = 0, checks = 0;
  bit done = 0;

  edge_stamp_unit #(.W(W), .DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .echo_invert(echo_invert),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_stamp(rsp_stamp), .rsp_level(rsp_level),
    .rsp_new(rsp_new), .rsp_armed(rsp_armed), .echo_out(echo_out)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference state
  int  m_pres, m_time, m_age, m_stamp;
  bit  m_armed, m_pipe[$], m_lvl_d, m_prev, m_echo;
  bit  m_rv, m_rl, m_rn, m_ra;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pres = 0; m_time = 0; m_age = 0; m_armed = 0;
      m_pipe = '{0, 0}; m_lvl_d = 0; m_prev = 0; m_echo = 0;
      m_rv = 0; m_rl = 0; m_rn = 0; m_ra = 0; m_stamp = 0;
    end else begin
      bit t, lvl, rs, acc;
      int now;
      t   = (m_pres == DIV - 1);
      lvl = m_pipe[1];
      rs  = lvl && !m_lvl_d;
      now = rs ? m_time : ((m_time - m_age) & MASK);
      acc = req_valid && !m_rv;
      if (acc) begin
        m_rv = 1; m_stamp = now; m_rl = lvl; m_rn = lvl && !m_prev;
        m_ra = m_armed || rs;
        if (lvl && !m_prev) m_echo = 1;
        else if (!lvl && m_prev) m_echo = 0;
        m_prev = lvl;
      end else if (m_rv && rsp_ready) m_rv = 0;
      if (rs) begin m_age = t ? 1 : 0; m_armed = 1; end
      else if (m_armed && t) m_age = (m_age + 1) & MASK;
      if (t) m_time = (m_time + 1) & MASK;
      m_pres = (m_pres + 1) % DIV;
      m_lvl_d = lvl;
      m_pipe = '{pps_in, m_pipe[0]};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 req_ready", int'(req_ready), int'(!m_rv));
      check("R8 rsp_valid", int'(rsp_valid), int'(m_rv));
      if (m_rv) begin
        check("R4 rsp_stamp", int'(rsp_stamp), m_stamp);
        check("R3 rsp_level", int'(rsp_level), int'(m_rl));
        check("R6 rsp_new", int'(rsp_new), int'(m_rn));
        check("R2 rsp_armed", int'(rsp_armed), int'(m_ra));
      end
      check("R7 echo_out", int'(echo_out), int'(m_echo ^ echo_invert));
    end
  end

  task automatic poll(output int st, output bit lv, output bit ar);
    req_valid = 1'b1;
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    req_valid = 1'b0;
    st = rsp_stamp; lv = rsp_level; ar = rsp_armed;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s1, s2; bit l1, a1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 req_ready", int'(req_ready), 1);
    check("R1 echo_out", int'(echo_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R2: no edge yet, not armed, stamp is the raw timebase
    poll(s1, l1, a1);
    check("R1 armed before edge", int'(a1), 0);
    repeat (40) @(negedge clk);
    poll(s2, l1, a1);
    check("R2 timebase moved", int'(s2 != s1), 1);

    // R5: request lands exactly on the synchronized edge cycle
    pps_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R5 valid on edge poll", int'(rsp_valid), 1);
    check("R5 level on edge poll", int'(rsp_level), 1);
    check("R5 armed on edge poll", int'(rsp_armed), 1);
    s1 = rsp_stamp;
    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
    repeat (57) @(negedge clk);
    // R4: later poll returns the same stamp
    poll(s2, l1, a1);
    check("R4 stamp stable", s2, s1);
    check("R5 edge-cycle stamp", s2, s1);
    pps_in = 1'b0;
    repeat (5) @(negedge clk);
    poll(s2, l1, a1);

    // free-running mix of pulses, polls, back-pressure and inversion
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 60) == 0) pps_in = ~pps_in;
      req_valid   = ($urandom_range(0, 3) == 0);
      rsp_ready   = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 700) == 0) echo_invert = ~echo_invert;
      @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule